// File: doc/BRIEF.md
# Period-Register PWM Generator

This block drives a single pulse-width modulated output from an 8-bit period timer. The timer is clocked through a selectable prescaler (divide by 1, 4 or 16) and a two-bit quarter-phase counter. Together they form a 10-bit timebase that advances once per prescaled clock. The period register sets where the timer wraps. A 10-bit duty value, assembled from an 8-bit high register and a 2-bit low field in the control register, sets how long the output stays high in each period.

Software sets it up through a small write port. The usual order is the period, then the duty, then the mode field, and last the timer enable with its prescale choice. The duty value is copied into a shadow register at the start of every period, so a new duty written mid-period is applied cleanly from the next period on. A duty value that reaches or passes the number of timebase steps in one period keeps the output high continuously.

Top module: `pwm_period_gen`

## Requirements
- R1: After reset all configuration registers are zero and the output stays low until the block is configured and enabled.
- R2: While running, the output period is (period + 1) × 4 × P clock cycles. P is chosen by bits 1:0 of the timer register (address 3): 00 selects 1, 01 selects 4, and 10 or 11 select 16. Bit 2 of the same register enables the timer.
- R3: The output is high for duty × P clock cycles at the start of each period. The duty value is {duty-high register (address 1), control register bits 5:4 (address 2)}.
- R4: A duty value of zero keeps the output low for the whole period.
- R5: A duty value of 4 × (period + 1) or more keeps the output high continuously.
- R6: A duty write made during a period does not change that period's pulse. The new value applies from the next period start.
- R7: The block runs only when the timer enable is set and control register bits 3:2 are both 1. Otherwise the output is low within two cycles and the timebase holds at zero.
- R8: When the write that starts the block is sampled at a clock edge, the output is low after that edge and after the next one. It is high after the second edge following the write (for a nonzero duty).
- R9: Any register write restarts the prescaler count. With P = 16, a write sampled when the prescaler holds j (j < 15) lengthens the current period by j + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_addr | input | 2 | Register select: 0 period, 1 duty high, 2 control, 3 timer |
| wr_data | input | 8 | Write data |
| pwm_o | output | 1 | PWM output |

## Verification
A write lands in the register file on the edge that samples it. The timebase starts or stops on the next edge, and the output register follows one edge after that. So the start and stop latency is two cycles, and pulse widths and periods are counted from an observed rising edge of the output. The bench drives and samples only on falling clock edges, so each sample holds the values settled after exactly one known rising edge. Pulse-width, period and mid-period tests count in these falling-edge steps from the detected rise. The prescaler-restart test places its write at a fixed offset from the rise so that the expected extension is known exactly.

// File: rtl/pwm_period_pkg.sv
package pwm_period_pkg;

    // Register selects on the write port
    typedef enum logic [1:0] {
        SEL_PERIOD  = 2'd0,
        SEL_DUTY_HI = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_TIMER   = 2'd3
    } reg_sel_e;

    // Prescale select codes
    typedef enum logic [1:0] {
        PS_DIV1  = 2'b00,
        PS_DIV4  = 2'b01,
        PS_DIV16 = 2'b10
    } ps_sel_e;

    // Value of mode bits 3:2 that selects PWM operation
    localparam logic [1:0] PWM_MODE_KEY = 2'b11;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
    parameter int TMR_W = 8,
    parameter int SUB_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_addr,
    input  logic [TMR_W-1:0]       wr_data,
    output logic [TMR_W-1:0]       period,
    output logic [TMR_W+SUB_W-1:0] duty,
    output logic [1:0]             ps_sel,
    output logic                   run_cfg
);
    import pwm_period_pkg::*;

    localparam int LO_MSB = SUB_W + 3;

    typedef struct packed {
        logic [TMR_W-1:0] period;
        logic [TMR_W-1:0] duty_hi;
        logic [SUB_W-1:0] duty_lo;
        logic [3:0]       mode;
        logic             tmr_on;
        logic [1:0]       ps;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_PERIOD:  cfg_d.period  = wr_data;
                SEL_DUTY_HI: cfg_d.duty_hi = wr_data;
                SEL_CTRL: begin
                    cfg_d.duty_lo = wr_data[LO_MSB:4];
                    cfg_d.mode    = wr_data[3:0];
                end
                SEL_TIMER: begin
                    cfg_d.tmr_on = wr_data[2];
                    cfg_d.ps     = wr_data[1:0];
                end
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign period  = cfg_q.period;
    assign duty    = {cfg_q.duty_hi, cfg_q.duty_lo};
    assign ps_sel  = cfg_q.ps;
    assign run_cfg = cfg_q.tmr_on && (cfg_q.mode[3:2] == PWM_MODE_KEY);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int TMR_W = 8,
    parameter int SUB_W = 2,
    parameter int PRE_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_cfg,
    input  logic                   clr_pre,
    input  logic [1:0]             ps_sel,
    input  logic [TMR_W-1:0]       period,
    output logic                   run_q,
    output logic [TMR_W+SUB_W-1:0] count,
    output logic                   wrap,
    output logic                   load
);
    import pwm_period_pkg::*;

    localparam logic [PRE_W-1:0] TOP_DIV1  = '0;
    localparam logic [PRE_W-1:0] TOP_DIV4  = PRE_W'(3);
    localparam logic [PRE_W-1:0] TOP_DIV16 = PRE_W'(15);

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] pre;
        logic [SUB_W-1:0] sub;
        logic [TMR_W-1:0] tmr;
    } tb_t;

    tb_t              tb_d, tb_q;
    logic [PRE_W-1:0] pre_top;
    logic             step;
    logic             wrap_c;

    always_comb begin
        case (ps_sel_e'(ps_sel))
            PS_DIV1: pre_top = TOP_DIV1;
            PS_DIV4: pre_top = TOP_DIV4;
            default: pre_top = TOP_DIV16;
        endcase

        step   = tb_q.run && (tb_q.pre == pre_top);
        wrap_c = step && (tb_q.sub == '1) && (tb_q.tmr == period);

        tb_d = tb_q;
        if (!run_cfg) begin
            tb_d = '0;
        end else if (!tb_q.run) begin
            tb_d     = '0;
            tb_d.run = 1'b1;
        end else begin
            tb_d.pre = step ? '0 : tb_q.pre + 1'b1;
            if (step) begin
                tb_d.sub = tb_q.sub + 1'b1;
                if (tb_q.sub == '1) begin
                    tb_d.tmr = (tb_q.tmr == period) ? '0 : tb_q.tmr + 1'b1;
                end
            end
            if (clr_pre) tb_d.pre = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign run_q = tb_q.run;
    assign count = {tb_q.tmr, tb_q.sub};
    assign wrap  = wrap_c;
    assign load  = run_cfg && (!tb_q.run || wrap_c);

endmodule

// File: rtl/pwm_duty_out.sv
module pwm_duty_out #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] duty,
    output logic [CNT_W-1:0] shadow,
    output logic             pwm
);
    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic             pwm;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d        = out_q;
        out_d.shadow = load ? duty : out_q.shadow;
        out_d.pwm    = run && (count < out_q.shadow);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign shadow = out_q.shadow;
    assign pwm    = out_q.pwm;

endmodule

// File: rtl/pwm_period_gen.sv
module pwm_period_gen #(
    parameter int TMR_W = 8,
    parameter int SUB_W = 2,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    output logic             pwm_o
);
    localparam int CNT_W = TMR_W + SUB_W;

    logic [TMR_W-1:0] period_cfg;
    logic [CNT_W-1:0] duty_cfg;
    logic [1:0]       ps_cfg;
    logic             run_cfg;
    logic             run_q;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic             load;
    logic [CNT_W-1:0] shadow_q;

    pwm_cfg_regs #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .period  (period_cfg),
        .duty    (duty_cfg),
        .ps_sel  (ps_cfg),
        .run_cfg (run_cfg)
    );

    pwm_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W), .PRE_W(PRE_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_cfg (run_cfg),
        .clr_pre (wr_en),
        .ps_sel  (ps_cfg),
        .period  (period_cfg),
        .run_q   (run_q),
        .count   (count),
        .wrap    (wrap),
        .load    (load)
    );

    pwm_duty_out #(.CNT_W(CNT_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .load   (load),
        .count  (count),
        .duty   (duty_cfg),
        .shadow (shadow_q),
        .pwm    (pwm_o)
    );

endmodule

// File: rtl/pwm_period_chk.sv
module pwm_period_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_q,
    input logic             wrap,
    input logic             load,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] duty_cfg,
    input logic [CNT_W-1:0] shadow_q,
    input logic             pwm_o
);
    // Stopped timebase forces the output low on the next edge
    assert_stopped_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> !pwm_o);

    // Zero latched duty never drives the output high
    assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && shadow_q == '0) |=> !pwm_o);

    // Period end returns the timebase to zero
    assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> count == '0);

    // Latched duty changes only at a period start
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(shadow_q));

    // Period start takes the configured duty
    assert_shadow_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> shadow_q == $past(duty_cfg));

    // First cycle after start: output follows whether duty is nonzero
    assert_start_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |=> pwm_o == ($past(shadow_q) != '0));

endmodule

bind pwm_period_gen pwm_period_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_q    (run_q),
    .wrap     (wrap),
    .load     (load),
    .count    (count),
    .duty_cfg (duty_cfg),
    .shadow_q (shadow_q),
    .pwm_o    (pwm_o)
);

// File: tb/tb_pwm_period_gen.sv
module tb_pwm_period_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_period_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the write is sampled at the next rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic setup_stopped(input int pr, input int duty);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'(pr));
        wr(2'd1, 8'(duty >> 2));
        wr(2'd2, {2'b00, 2'(duty & 3), 4'b1100});
    endtask

    task automatic setup_run(input int pr, input int duty, input int ps);
        setup_stopped(pr, duty);
        wr(2'd3, {5'b0, 1'b1, 2'(ps)});
    endtask

    task automatic wait_rise(output bit found);
        logic prev;
        found = 1'b0;
        prev  = pwm_o;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (pwm_o && !prev) begin
                found = 1'b1;
                break;
            end
            prev = pwm_o;
        end
    endtask

    task automatic measure(input string tag, input int exp_hi, input int exp_per);
        bit   found;
        int   hi;
        int   n;
        logic prev;
        wait_rise(found);
        check({tag, " rise seen"}, int'(found), 1);
        hi = 0;
        n  = 0;
        prev = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            if (pwm_o) hi++;
            prev = pwm_o;
            @(negedge clk);
            n++;
            if (pwm_o && !prev) break;
        end
        check({tag, " high time"}, hi, exp_hi);
        check({tag, " period"}, n, exp_per);
    endtask

    task automatic count_level(input int len, input logic lvl, output int cnt);
        cnt = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pwm_o == lvl) cnt++;
        end
    endtask

    task automatic t_reset;
        int c;
        count_level(16, 1'b1, c);
        check("R1 output low after reset", c, 0);
    endtask

    task automatic t_shape;
        setup_run(3, 5, 0);
        measure("R2 R3 pr3 d5 div1", 5, 16);
        setup_run(7, 13, 1);
        measure("R2 R3 pr7 d13 div4", 52, 128);
        setup_run(1, 3, 2);
        measure("R2 R3 pr1 d3 div16", 48, 128);
        setup_run(0, 1, 3);
        measure("R2 R3 pr0 d1 code3", 16, 64);
        setup_run(63, 255, 0);
        measure("R3 pr63 d255 div1", 255, 256);
    endtask

    task automatic t_full;
        int c;
        setup_run(63, 300, 0);
        repeat (4) @(negedge clk);
        count_level(600, 1'b0, c);
        check("R5 duty above period stays high", c, 0);
        setup_run(63, 256, 0);
        repeat (4) @(negedge clk);
        count_level(600, 1'b0, c);
        check("R5 duty equal to period stays high", c, 0);
    endtask

    task automatic t_zero;
        int c;
        setup_run(5, 0, 0);
        count_level(200, 1'b1, c);
        check("R4 zero duty stays low", c, 0);
    endtask

    task automatic t_gate;
        int c;
        setup_run(3, 5, 0);
        measure("R7 baseline", 5, 16);
        wr(2'd2, {2'b00, 2'd1, 4'b0000});
        repeat (2) @(negedge clk);
        count_level(100, 1'b1, c);
        check("R7 mode off holds low", c, 0);
        wr(2'd2, {2'b00, 2'd1, 4'b1111});
        measure("R7 mode 1111 runs", 5, 16);
        wr(2'd3, 8'h00);
        repeat (2) @(negedge clk);
        count_level(100, 1'b1, c);
        check("R7 timer off holds low", c, 0);
    endtask

    task automatic t_latency;
        setup_stopped(3, 5);
        wr(2'd3, 8'h04);
        check("R8 low after write edge", int'(pwm_o), 0);
        @(negedge clk);
        check("R8 low after second edge", int'(pwm_o), 0);
        @(negedge clk);
        check("R8 high after third edge", int'(pwm_o), 1);
    endtask

    task automatic t_shadow;
        bit found;
        int hi;
        setup_run(15, 40, 0);
        wait_rise(found);
        check("R6 rise seen", int'(found), 1);
        hi = 1;
        wr(2'd1, 8'd2);
        for (int i = 0; i < 200; i++) begin
            if (!pwm_o) break;
            hi++;
            @(negedge clk);
        end
        check("R6 current pulse keeps old duty", hi, 40);
        measure("R6 next period new duty", 8, 64);
    endtask

    task automatic t_prescale_clear;
        bit   found;
        int   n;
        logic prev;
        setup_run(1, 4, 2);
        wait_rise(found);
        check("R9 rise seen", int'(found), 1);
        n = 0;
        repeat (4) begin
            @(negedge clk);
            n++;
        end
        wr(2'd0, 8'd1);
        n++;
        prev = pwm_o;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            n++;
            if (pwm_o && !prev) break;
            prev = pwm_o;
        end
        check("R9 write restarts prescaler", n, 134);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_shape();
        t_full();
        t_zero();
        t_gate();
        t_shadow();
        t_prescale_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule